// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block picks the reference divider M, the feedback multiplier N and the post-divider code PL of a clock PLL. The chosen set brings the PLL output as close as possible to a requested frequency. The caller places the target and reference frequencies, both in whole MHz, on the inputs and pulses `start`. The engine then scans candidates in a fixed order: post-divider codes in ascending order, then M in ascending order, then at most two N values. It keeps the candidate with the smallest absolute output error. When the scan ends, it publishes the winning coefficients with a one-cycle `done` pulse.

Every quotient comes from one shared restoring divider that resolves one bit per clock. The run time therefore depends on the number of candidates visited. The scan ends early when a candidate with zero error is found. If no candidate meets the limits, `noMatch` is raised and the engine reports a fixed default coefficient set.

Top module: `pll_coeff_search`

## Requirements
- R1: After reset, `mOut`, `nOut` and `plOut` are 0, and `done` and `noMatch` are low.
- R2: The post-divider code maps to a divide value by lookup. Codes 0 to 14 give 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24 and 32. A reported `plOut` is a code, not a divide value.
- R3: The padded target is T + T/50, using integer division. The VCO upper limit is the larger of 2064 MHz and the padded target. The lower limit is 1000 MHz.
- R4: The upper divide bound is ceil(VCOmax / padded) and the lower bound is floor(1000 / padded). Both are clamped to 1..32. Each bound then becomes the lowest code in 0..13 whose divide value is at least the bound, or code 14 if no such code exists. Codes run from the lower code to the upper code.
- R5: An M is tried only when floor(ref/M) lies in 12..38 and M lies in 1..255. When no M qualifies, the result is no-match.
- R6: For a code with divide value D and an M, the N candidates are floor(T·D·M/ref) up to the ceiling of the same quotient. The M is skipped if the floor exceeds 255. N values below 8 are passed over, and an N above 255 ends that M.
- R7: A candidate is accepted only when floor(ref·N/M) lies in [1000, VCOmax]. Its output is floor((VCO + D/2)/D). Its error is the absolute difference between that output and T.
- R8: The stored best changes only on a strictly smaller error, so the earliest candidate in scan order wins a tie. The scan stops once a zero-error candidate is stored.
- R9: If no candidate is accepted, `noMatch` is high and the outputs are M=255, N=8, PL=0.
- R10: `done` is a single-cycle pulse. The results are valid from that cycle and hold until the next `done`, whatever the inputs do.
- R11: A `start` pulse that arrives while a search is running has no effect. The running search finishes on its own inputs and produces one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a search; accepted only when the engine is idle |
| targetMhz | input | 16 | Requested output frequency in MHz, sampled on start |
| refMhz | input | 16 | Reference frequency in MHz, sampled on start |
| done | output | 1 | One-cycle pulse when results are published |
| mOut | output | 8 | Chosen reference divider |
| nOut | output | 8 | Chosen feedback multiplier |
| plOut | output | 4 | Chosen post-divider code |
| noMatch | output | 1 | High when no candidate met the limits |

## Verification
A wrong internal state shows up only at the next `done` pulse, as a coefficient set that differs from an exhaustive search carried out by the same rules. Corrupted divide bounds or an error in the code table shift `plOut`. A wrong N window or a wrong tie rule changes `nOut` or `mOut`. Broken early exit or loop control shows up first as a delayed or missing `done`, and only later as wrong values. For these reasons each search is compared in full against a model at its `done` pulse, and the outputs are checked again for stability over the following cycles.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [2:0] {
    OP_PAD, OP_HI, OP_LO, OP_MHI, OP_MLO, OP_NFLOOR, OP_VCO, OP_OUT
  } divOp_e;

  typedef struct packed {
    logic   load;
    logic   divGo;
    divOp_e op;
    logic   plFirst;
    logic   plNext;
    logic   mFirst;
    logic   mNext;
    logic   nNext;
    logic   publish;
  } ctlStrobe_t;

  typedef struct packed {
    logic divDone;
    logic mEmpty;
    logic mLast;
    logic plLast;
    logic nTooBig;
    logic nBelow;
    logic nAbove;
    logic nLast;
    logic vcoOk;
    logic exact;
  } dpFlags_t;

  // post-divider code to divide value (non-monotonic lookup)
  function automatic logic [5:0] divOf(input logic [3:0] code);
    case (code)
      4'd0:  divOf = 6'd1;
      4'd1:  divOf = 6'd2;
      4'd2:  divOf = 6'd3;
      4'd3:  divOf = 6'd4;
      4'd4:  divOf = 6'd5;
      4'd5:  divOf = 6'd6;
      4'd6:  divOf = 6'd8;
      4'd7:  divOf = 6'd10;
      4'd8:  divOf = 6'd12;
      4'd9:  divOf = 6'd16;
      4'd10: divOf = 6'd12;
      4'd11: divOf = 6'd16;
      4'd12: divOf = 6'd20;
      4'd13: divOf = 6'd24;
      default: divOf = 6'd32;
    endcase
  endfunction

  // lowest code in 0..13 whose divide value reaches the bound, else 14
  function automatic logic [3:0] codeOf(input logic [5:0] bound);
    codeOf = 4'd14;
    for (int i = 13; i >= 0; i--) begin
      if (divOf(4'(i)) >= bound) codeOf = 4'(i);
    end
  endfunction

endpackage

// File: rtl/pll_search_div.sv
module pll_search_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [W-1:0]     quoR, remR, dvdQ, dvsQ;
  logic [W:0]       remShift;
  logic [W+1:0]     diff;

  always_comb begin
    remShift = {remR, quoR[W-1]};
    diff     = {1'b0, remShift} - {2'b0, dvsQ};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      quoR <= '0;
      remR <= '0;
      dvdQ <= '0;
      dvsQ <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        quoR <= dividend;
        remR <= '0;
        dvdQ <= dividend;
        dvsQ <= divisor;
        cnt  <= CNT_W'(W);
        busy <= 1'b1;
      end else if (busy) begin
        if (diff[W+1]) begin
          remR <= remShift[W-1:0];
          quoR <= {quoR[W-2:0], 1'b0};
        end else begin
          remR <= diff[W-1:0];
          quoR <= {quoR[W-2:0], 1'b1};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quoR;
  assign remainder = remR;

  // every quotient the search relies on must be exact
  assert_div_exact_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && dvsQ != '0) |->
      (({{W{1'b0}}, quoR} * {{W{1'b0}}, dvsQ} + {{W{1'b0}}, remR}) == {{W{1'b0}}, dvdQ})
      && (remR < dvsQ));

endmodule

// File: rtl/pll_search_dp.sv
module pll_search_dp
  import pll_search_pkg::*;
#(
  parameter int FW      = 16,
  parameter int DW      = 32,
  parameter int MW      = 8,
  parameter int NW      = 8,
  parameter int CW      = 4,
  parameter int VCO_MIN = 1000,
  parameter int VCO_MAX = 2064,
  parameter int U_MIN   = 12,
  parameter int U_MAX   = 38,
  parameter int M_MIN   = 1,
  parameter int M_MAX   = 255,
  parameter int N_MIN   = 8,
  parameter int N_MAX   = 255,
  parameter int PL_MIN  = 1,
  parameter int PL_MAX  = 32,
  parameter int PAD_DIV = 50
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    st,
  input  logic [FW-1:0] targetMhz,
  input  logic [FW-1:0] refMhz,
  output dpFlags_t      flags,
  output logic [MW-1:0] mOut,
  output logic [NW-1:0] nOut,
  output logic [CW-1:0] plOut,
  output logic          noMatch
);
  localparam logic [DW-1:0] VMIN_V = DW'(VCO_MIN);
  localparam logic [DW-1:0] VMAX_V = DW'(VCO_MAX);
  localparam logic [DW-1:0] MMIN_V = DW'(M_MIN);
  localparam logic [DW-1:0] MMAX_V = DW'(M_MAX);
  localparam logic [NW:0]   NMIN_V = (NW+1)'(N_MIN);
  localparam logic [NW:0]   NMAX_V = (NW+1)'(N_MAX);

  logic [FW-1:0] tgtQ, refQ;
  logic [DW-1:0] padT, vcoHi, mLo, mHi, vco, bestErr;
  logic [5:0]    hiB, loB;
  logic [CW-1:0] pl, bestPl;
  logic [MW-1:0] m, bestM;
  logic [NW:0]   nCur, nTop;
  logic [NW-1:0] bestN;
  logic          nTooBig, found;
  divOp_e        opQ;

  logic [DW-1:0] dvd, dvs, quo, rem, padSum, delta, tgtW, refW, divW;
  logic          divDone;
  logic [3:0]    codeLo, codeHi;

  function automatic logic [5:0] clampDiv(input logic [DW-1:0] q);
    if (q < DW'(PL_MIN))      clampDiv = 6'(PL_MIN);
    else if (q > DW'(PL_MAX)) clampDiv = 6'(PL_MAX);
    else                      clampDiv = q[5:0];
  endfunction

  always_comb begin
    tgtW   = DW'(tgtQ);
    refW   = DW'(refQ);
    divW   = DW'(divOf(4'(pl)));
    codeLo = codeOf(loB);
    codeHi = codeOf(hiB);
    padSum = tgtW + quo;
    delta  = (quo >= tgtW) ? quo - tgtW : tgtW - quo;
    case (st.op)
      OP_PAD:    begin dvd = tgtW;                 dvs = DW'(PAD_DIV);   end
      OP_HI:     begin dvd = vcoHi;                dvs = padT;           end
      OP_LO:     begin dvd = VMIN_V;               dvs = padT;           end
      OP_MHI:    begin dvd = refW;                 dvs = DW'(U_MIN);     end
      OP_MLO:    begin dvd = refW;                 dvs = DW'(U_MAX + 1); end
      OP_NFLOOR: begin dvd = tgtW * divW * DW'(m); dvs = refW;           end
      OP_VCO:    begin dvd = refW * DW'(nCur);     dvs = DW'(m);         end
      default:   begin dvd = vco + (divW >> 1);    dvs = divW;           end
    endcase
  end

  pll_search_div #(.W(DW)) i_div (
    .clk(clk), .rstN(rstN), .go(st.divGo), .dividend(dvd), .divisor(dvs),
    .done(divDone), .quotient(quo), .remainder(rem)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtQ <= '0; refQ <= '0; padT <= '0; vcoHi <= '0;
      hiB <= '0; loB <= '0; mLo <= '0; mHi <= '0; vco <= '0;
      pl <= '0; m <= '0; nCur <= '0; nTop <= '0; nTooBig <= 1'b0;
      bestM <= '0; bestN <= '0; bestPl <= '0; bestErr <= '1; found <= 1'b0;
      opQ <= OP_PAD;
      mOut <= '0; nOut <= '0; plOut <= '0; noMatch <= 1'b0;
    end else begin
      if (st.load) begin
        tgtQ    <= targetMhz;
        refQ    <= refMhz;
        bestM   <= MW'(M_MAX);
        bestN   <= NW'(N_MIN);
        bestPl  <= '0;
        bestErr <= '1;
        found   <= 1'b0;
      end
      if (st.divGo) opQ <= st.op;
      if (divDone) begin
        case (opQ)
          OP_PAD: begin
            padT  <= padSum;
            vcoHi <= (VMAX_V < padSum) ? padSum : VMAX_V;
          end
          OP_HI:  hiB <= clampDiv(quo + DW'(rem != '0));
          OP_LO:  loB <= clampDiv(quo);
          OP_MHI: mHi <= (quo > MMAX_V) ? MMAX_V : quo;
          OP_MLO: mLo <= (quo + 1'b1 < MMIN_V) ? MMIN_V : quo + 1'b1;
          OP_NFLOOR: begin
            nTooBig <= quo > DW'(N_MAX);
            nCur    <= quo[NW:0];
            nTop    <= quo[NW:0] + (NW+1)'(rem != '0);
          end
          OP_VCO: vco <= quo;
          default: begin
            if (delta < bestErr) begin
              bestErr <= delta;
              bestM   <= m;
              bestN   <= nCur[NW-1:0];
              bestPl  <= pl;
              found   <= 1'b1;
            end
          end
        endcase
      end
      if (st.plFirst) pl <= CW'(codeLo);
      if (st.plNext)  pl <= pl + 1'b1;
      if (st.mFirst)  m <= mLo[MW-1:0];
      if (st.mNext)   m <= m + 1'b1;
      if (st.nNext)   nCur <= nCur + 1'b1;
      if (st.publish) begin
        mOut    <= bestM;
        nOut    <= bestN;
        plOut   <= bestPl;
        noMatch <= !found;
      end
    end
  end

  always_comb begin
    flags.divDone = divDone;
    flags.mEmpty  = mLo > mHi;
    flags.mLast   = DW'(m) == mHi;
    flags.plLast  = pl == CW'(codeHi);
    flags.nTooBig = nTooBig;
    flags.nBelow  = nCur < NMIN_V;
    flags.nAbove  = nCur > NMAX_V;
    flags.nLast   = nCur == nTop;
    flags.vcoOk   = (vco >= VMIN_V) && (vco <= vcoHi);
    flags.exact   = found && (bestErr == '0);
  end

  assert_code_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (divDone && opQ == OP_OUT) |-> (pl >= CW'(codeLo) && pl <= CW'(codeHi)));

  assert_m_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (divDone && opQ == OP_OUT) |-> (DW'(m) >= mLo && DW'(m) <= mHi));

  assert_best_never_worse_R8: assert property (@(posedge clk) disable iff (!rstN)
    !st.load |=> (bestErr <= $past(bestErr)));

  assert_default_on_nomatch_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st.publish && !found) |=>
      (noMatch && mOut == MW'(M_MAX) && nOut == NW'(N_MIN) && plOut == '0));

  assert_inputs_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    !st.load |=> ($stable(tgtQ) && $stable(refQ)));

endmodule

// File: rtl/pll_search_ctl.sv
module pll_search_ctl
  import pll_search_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  dpFlags_t   flags,
  output ctlStrobe_t st,
  output logic       done
);
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_DECIDE, S_NCHK, S_FIN} state_e;

  state_e state, nxt;
  divOp_e curOp, opNext;
  logic   doStep, doAdv;

  always_comb begin
    st     = '0;
    st.op  = curOp;
    nxt    = state;
    opNext = curOp;
    doStep = 1'b0;
    doAdv  = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        st.load = 1'b1;
        opNext  = OP_PAD;
        nxt     = S_ISSUE;
      end
      S_ISSUE: begin
        st.divGo = 1'b1;
        nxt      = S_WAIT;
      end
      S_WAIT: if (flags.divDone) nxt = S_DECIDE;
      S_DECIDE: begin
        case (curOp)
          OP_PAD: begin opNext = OP_HI;  nxt = S_ISSUE; end
          OP_HI:  begin opNext = OP_LO;  nxt = S_ISSUE; end
          OP_LO:  begin opNext = OP_MHI; nxt = S_ISSUE; end
          OP_MHI: begin opNext = OP_MLO; nxt = S_ISSUE; end
          OP_MLO: begin
            if (flags.mEmpty) nxt = S_FIN;
            else begin
              st.plFirst = 1'b1;
              st.mFirst  = 1'b1;
              opNext     = OP_NFLOOR;
              nxt        = S_ISSUE;
            end
          end
          OP_NFLOOR: begin
            if (flags.nTooBig) doAdv = 1'b1;
            else nxt = S_NCHK;
          end
          OP_VCO: begin
            if (flags.vcoOk) begin opNext = OP_OUT; nxt = S_ISSUE; end
            else doStep = 1'b1;
          end
          default: begin
            if (flags.exact) nxt = S_FIN;
            else doStep = 1'b1;
          end
        endcase
      end
      S_NCHK: begin
        if (flags.nAbove)      doAdv = 1'b1;
        else if (flags.nBelow) doStep = 1'b1;
        else begin opNext = OP_VCO; nxt = S_ISSUE; end
      end
      S_FIN: begin
        st.publish = 1'b1;
        nxt        = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase

    if (doStep) begin
      if (flags.nLast) doAdv = 1'b1;
      else begin
        st.nNext = 1'b1;
        nxt      = S_NCHK;
      end
    end
    if (doAdv) begin
      if (flags.mLast) begin
        if (flags.plLast) nxt = S_FIN;
        else begin
          st.plNext = 1'b1;
          st.mFirst = 1'b1;
          opNext    = OP_NFLOOR;
          nxt       = S_ISSUE;
        end
      end else begin
        st.mNext = 1'b1;
        opNext   = OP_NFLOOR;
        nxt      = S_ISSUE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      curOp <= OP_PAD;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      curOp <= opNext;
      done  <= (state == S_FIN);
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_no_reload_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && start) |=> (state != S_ISSUE || curOp != OP_PAD));

endmodule

// File: rtl/pll_coeff_search.sv
module pll_coeff_search
  import pll_search_pkg::*;
#(
  parameter int FW = 16,
  parameter int MW = 8,
  parameter int NW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [FW-1:0] targetMhz,
  input  logic [FW-1:0] refMhz,
  output logic          done,
  output logic [MW-1:0] mOut,
  output logic [NW-1:0] nOut,
  output logic [CW-1:0] plOut,
  output logic          noMatch
);
  ctlStrobe_t st;
  dpFlags_t   flags;

  pll_search_ctl i_ctl (
    .clk(clk), .rstN(rstN), .start(start), .flags(flags), .st(st), .done(done)
  );

  pll_search_dp #(.FW(FW), .MW(MW), .NW(NW), .CW(CW)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .targetMhz(targetMhz), .refMhz(refMhz),
    .flags(flags), .mOut(mOut), .nOut(nOut), .plOut(plOut), .noMatch(noMatch)
  );

endmodule

// File: tb/test_pll_coeff_search.sv
`timescale 1ns/1ps
module test_pll_coeff_search;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] targetMhz = '0;
  logic [15:0] refMhz = '0;
  logic        done, noMatch;
  logic [7:0]  mOut, nOut;
  logic [3:0]  plOut;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pll_coeff_search i_pll_coeff_search (
    .clk(clk), .rstN(rstN), .start(start), .targetMhz(targetMhz), .refMhz(refMhz),
    .done(done), .mOut(mOut), .nOut(nOut), .plOut(plOut), .noMatch(noMatch)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint divVal(input int c);
    case (c)
      0: return 1;   1: return 2;   2: return 3;   3: return 4;   4: return 5;
      5: return 6;   6: return 8;   7: return 10;  8: return 12;  9: return 16;
      10: return 12; 11: return 16; 12: return 20; 13: return 24; default: return 32;
    endcase
  endfunction

  // exhaustive search by the stated rules
  function automatic void model(input longint t, input longint r, output longint em,
                                output longint en, output longint ep, output bit enm);
    longint tv, vhi, hb, lb, lc, hc, be, vt, n, n2, vco, lwv, d, u;
    bit hit;
    tv = t + t / 50;
    vhi = (2064 < tv) ? tv : 2064;
    hb = (vhi + tv - 1) / tv; if (hb > 32) hb = 32; if (hb < 1) hb = 1;
    lb = 1000 / tv;           if (lb > 32) lb = 32; if (lb < 1) lb = 1;
    lc = 14; hc = 14;
    for (int c = 13; c >= 0; c--) begin
      if (divVal(c) >= lb) lc = c;
      if (divVal(c) >= hb) hc = c;
    end
    em = 255; en = 8; ep = 0; be = 64'h7fffffffffffffff; hit = 0;
    for (longint p = lc; p <= hc; p++) begin
      vt = t * divVal(int'(p));
      for (longint m = 1; m <= 255; m++) begin
        u = r / m;
        if (u < 12 || u > 38) continue;
        n  = vt * m / r;
        n2 = (vt * m + r - 1) / r;
        if (n > 255) continue;
        for (longint k = n; k <= n2; k++) begin
          if (k < 8) continue;
          if (k > 255) break;
          vco = r * k / m;
          if (vco >= 1000 && vco <= vhi) begin
            lwv = (vco + divVal(int'(p)) / 2) / divVal(int'(p));
            d = (lwv > t) ? lwv - t : t - lwv;
            if (d < be) begin be = d; em = m; en = k; ep = p; hit = 1; end
          end
        end
      end
    end
    enm = !hit;
  endfunction

  task automatic pulseStart(input int t, input int r);
    @(negedge clk);
    targetMhz = 16'(t); refMhz = 16'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=0 expected=1 (no done pulse)");
    end
  endtask

  task automatic compare(input int t, input int r, input string tag);
    longint em, en, ep; bit enm;
    model(t, r, em, en, ep, enm);
    check({tag, " mOut"}, mOut, em);
    check({tag, " nOut"}, nOut, en);
    check({tag, " plOut"}, plOut, ep);
    check({tag, " noMatch"}, noMatch, enm);
  endtask

  task automatic runCase(input int t, input int r, input string tag);
    bit ok;
    pulseStart(t, r);
    waitDone(ok);
    if (ok) begin
      compare(t, r, tag);
      @(negedge clk);
      check("R10 done single pulse", done, 0);
    end
  endtask

  initial begin
    bit ok;
    int dn;
    logic [7:0] hm, hn; logic [3:0] hp; logic hx;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check("R1 reset mOut", mOut, 0);
    check("R1 reset nOut", nOut, 0);
    check("R1 reset plOut", plOut, 0);
    check("R1 reset done", done, 0);
    check("R1 reset noMatch", noMatch, 0);
    rstN = 1'b1;

    runCase(400, 38, "R7 exact hit");
    runCase(700, 27, "R2 code lookup");
    runCase(3000, 30, "R3 raised VCO limit");
    check("R3 raised limit accepts", noMatch, 0);
    runCase(5, 20, "R4 top code only");
    runCase(11, 11, "R5 ref too low");
    check("R9 default M", mOut, 255);
    check("R9 default N", nOut, 8);
    check("R9 default PL", plOut, 0);
    check("R9 flag", noMatch, 1);
    runCase(900, 20000, "R5 ref too high");
    runCase(1000, 12, "R6 single M window");
    runCase(1600, 13, "R6 N bound");
    runCase(333, 37, "R8 tie order");

    for (int i = 0; i < 14; i++) begin
      int t, r;
      t = int'($urandom_range(1200, 100));
      r = int'($urandom_range(50, 12));
      runCase(t, r, "R8 random");
    end

    // R10: results hold while inputs wander
    hm = mOut; hn = nOut; hp = plOut; hx = noMatch;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      targetMhz = 16'($urandom_range(2000, 1));
      refMhz = 16'($urandom_range(60, 1));
    end
    check("R10 hold mOut", mOut, hm);
    check("R10 hold nOut", nOut, hn);
    check("R10 hold plOut", plOut, hp);
    check("R10 hold noMatch", noMatch, hx);

    // R11: second start during a search is ignored
    pulseStart(640, 24);
    repeat (5) @(negedge clk);
    targetMhz = 16'd90; refMhz = 16'd11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(ok);
    if (ok) begin
      compare(640, 24, "R11 busy start");
      dn = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (done) dn++;
      end
      check("R11 no extra done", dn, 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule